// File: doc/BRIEF.md
# Hall Sensor Decoder with Fault Gating and Tachometer

This block turns three raw Hall sensor bits from a brushless motor into a clean rotor position code. Each bit is first brought into the clock domain through two flip-flops. It then passes a per-bit qualifier, which accepts a new level only after that level has held for a programmable number of clocks. The qualified code is tracked. A move between two legal codes produces a one-cycle transition strobe and flips a tachometer level, so the tach output runs at three times the electrical frequency.

The same block resolves the operator controls into a single drive command for the gate driver. Its inputs are an active-low start, an active-high brake, a direction level, and two external fault flags (supply undervoltage and overtemperature). An illegal Hall code of all zeros or all ones also counts as a fault. Faults are never latched: once every fault source is clean, the drive command returns to whatever start and brake request.

The drive command comes from a three-state machine. The states are OFF (every gate off), RUN (normal commutation) and BRAKE (all low-side switches on). The next state depends only on the current inputs, so any state can move to any other state in one clock. The named transitions are:
- to_off: start is inactive or a fault is present.
- to_brake: start is active, brake is high and there is no fault.
- to_run: start is active, brake is low and there is no fault.
- A state whose condition still holds stays where it is.

Top module: `hall_sense_ctrl`

## Requirements
- R1: A raw Hall bit reaches `hall_o` only after its synchronised value has differed from the accepted value for FILT_CYCLES consecutive clocks. With the default setting this is about 1.6 µs. A pulse shorter than that leaves `hall_o` and `strobe_o` unchanged. Bit order is A = bit 0, B = bit 1, C = bit 2.
- R2: After reset the outputs are as follows: `hall_o` = 3'b000, `tach_o` = 0, `strobe_o` = 0, `mode_o` = OFF.
- R3: Whenever `hall_o` is 3'b000 or 3'b111, `fault_o` is high. The flag drops in the same cycle that `hall_o` takes a legal code, because it is not latched.
- R4: `strobe_o` is high for exactly the one cycle in which `hall_o` takes a new value, provided both the old and the new code are legal. A change into or out of an illegal code gives no strobe.
- R5: `tach_o` changes level in exactly the cycles in which `strobe_o` is high, and holds its level in every other cycle.
- R6: `mode_o` uses the encoding OFF = 2'b00, RUN = 2'b01, BRAKE = 2'b10. It is registered one clock after the synchronised controls and the fault.
- R7: `mode_o` is OFF whenever start is inactive (`start_n_i` high) or any fault is present. This holds regardless of brake.
- R8: With start low, brake high and no fault, `mode_o` is BRAKE.
- R9: With start low, brake low and no fault, `mode_o` is RUN.
- R10: `dir_fwd_o` follows `dir_i` two clocks later. A value of 1 means forward and 0 means reverse.
- R11: `uv_flt_i` and `ot_flt_i` each raise `fault_o` two clocks after they are applied. The flag clears as soon as both flags are low, because it is not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_raw_i | input | 3 | Raw Hall bits {C,B,A}, asynchronous |
| start_n_i | input | 1 | Start request, active low |
| brake_i | input | 1 | Brake request, active high |
| dir_i | input | 1 | Direction request, 1 = forward |
| uv_flt_i | input | 1 | Supply undervoltage flag |
| ot_flt_i | input | 1 | Overtemperature flag |
| hall_o | output | 3 | Qualified Hall code {C,B,A} |
| strobe_o | output | 1 | One-cycle pulse on a legal transition |
| tach_o | output | 1 | Speed level, toggles on every legal transition |
| fault_o | output | 1 | Combined non-latched fault |
| dir_fwd_o | output | 1 | Synchronised direction, 1 = forward |
| mode_o | output | 2 | Drive command: 00 off, 01 run, 10 brake |

## Verification
The assertions check three things on every cycle:
- The qualifier's accepted level moves only after a full run of differing samples.
- Every strobe carries a legal code and comes with a tach flip, and the tach is otherwise still.
- Each state-machine transition matches its start, brake and fault condition one clock later.

Some behaviour can only be shown by the bench's scenarios. These are the exact cycle in which a Hall change appears and the rejection of a pulse one clock too short. They also include the full sweep of legal rotation in both directions, every illegal code entered and left, and all sixteen combinations of start, brake and the two fault flags. That sweep confirms that faults release without latching.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_RUN   = 2'b01,
        MODE_BRAKE = 2'b10
    } drive_mode_e;

    localparam int HALL_W = 3;

    function automatic logic hall_legal(input logic [HALL_W-1:0] code);
        return (code != '0) && (code != '1);
    endfunction

endpackage

// File: rtl/hsc_sync2.sv
module hsc_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/hsc_bit_filter.sv
module hsc_bit_filter #(
    parameter int FILT_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int            CW  = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(FILT_CYCLES - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == LIM) begin
                level_q <= sync_q[1];
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_o = level_q;

    // R1
    level_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> ($past(cnt_q) == LIM) && ($past(sync_q[1]) == level_q));
endmodule

// File: rtl/hsc_hall_track.sv
module hsc_hall_track
    import hsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALL_W-1:0] hall_f_i,
    output logic [HALL_W-1:0] hall_o,
    output logic              strobe_o,
    output logic              tach_o,
    output logic              bad_o
);
    logic [HALL_W-1:0] hall_q;
    logic              strobe_q;
    logic              tach_q;
    logic              step_d;

    always_comb begin
        step_d = (hall_f_i != hall_q) && hall_legal(hall_f_i) && hall_legal(hall_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hall_q   <= '0;
            strobe_q <= 1'b0;
            tach_q   <= 1'b0;
        end else begin
            hall_q   <= hall_f_i;
            strobe_q <= step_d;
            tach_q   <= tach_q ^ step_d;
        end
    end

    assign hall_o   = hall_q;
    assign strobe_o = strobe_q;
    assign tach_o   = tach_q;
    assign bad_o    = !hall_legal(hall_q);

    // R4
    strobe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> (hall_q != $past(hall_q)) && hall_legal($past(hall_q)) && !bad_o);
    // R5
    tach_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> (tach_q != $past(tach_q)));
    // R5
    tach_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_q |-> $stable(tach_q));
endmodule

// File: rtl/hsc_mode_fsm.sv
module hsc_mode_fsm
    import hsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_n_i,
    input  logic       brake_i,
    input  logic       fault_i,
    output logic [1:0] mode_o
);
    drive_mode_e state_q;
    drive_mode_e state_d;

    // next-state: to_off / to_brake / to_run
    always_comb begin
        if (start_n_i || fault_i) begin
            state_d = MODE_OFF;
        end else if (brake_i) begin
            state_d = MODE_BRAKE;
        end else begin
            state_d = MODE_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            MODE_OFF:   mode_o = 2'b00;
            MODE_RUN:   mode_o = 2'b01;
            MODE_BRAKE: mode_o = 2'b10;
            default:    mode_o = 2'b00;
        endcase
    end

    // R7
    to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_n_i || fault_i) |=> (mode_o == 2'b00));
    // R8
    to_brake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_n_i && brake_i && !fault_i) |=> (mode_o == 2'b10));
    // R9
    to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_n_i && !brake_i && !fault_i) |=> (mode_o == 2'b01));
endmodule

// File: rtl/hall_sense_ctrl.sv
module hall_sense_ctrl
    import hsc_pkg::*;
#(
    parameter int FILT_CYCLES = 400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  hall_raw_i,
    input  logic        start_n_i,
    input  logic        brake_i,
    input  logic        dir_i,
    input  logic        uv_flt_i,
    input  logic        ot_flt_i,
    output logic [2:0]  hall_o,
    output logic        strobe_o,
    output logic        tach_o,
    output logic        fault_o,
    output logic        dir_fwd_o,
    output logic [1:0]  mode_o
);
    localparam int         CTL_W   = 5;
    localparam logic [4:0] CTL_RST = 5'b00101;

    logic [HALL_W-1:0] hall_f;
    logic              hall_bad;
    logic [CTL_W-1:0]  ctl_s;
    logic              start_n_s;
    logic              brake_s;
    logic              dir_s;
    logic              uv_s;
    logic              ot_s;
    logic              fault_all;

    for (genvar i = 0; i < HALL_W; i++) begin : g_filt
        hsc_bit_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (hall_raw_i[i]),
            .level_o (hall_f[i])
        );
    end

    hsc_sync2 #(.W(CTL_W), .RST_VAL(CTL_RST)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ot_flt_i, uv_flt_i, dir_i, brake_i, start_n_i}),
        .q_o   (ctl_s)
    );

    assign {ot_s, uv_s, dir_s, brake_s, start_n_s} = ctl_s;

    hsc_hall_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .hall_f_i (hall_f),
        .hall_o   (hall_o),
        .strobe_o (strobe_o),
        .tach_o   (tach_o),
        .bad_o    (hall_bad)
    );

    assign fault_all = hall_bad | uv_s | ot_s;

    hsc_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_n_i (start_n_s),
        .brake_i   (brake_s),
        .fault_i   (fault_all),
        .mode_o    (mode_o)
    );

    assign fault_o   = fault_all;
    assign dir_fwd_o = dir_s;

    // R3
    illegal_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hall_o == 3'b000) || (hall_o == 3'b111)) |-> fault_o);
    // R7
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> (mode_o == 2'b00));
endmodule

// File: tb/sim_hall_sense_ctrl.sv
`timescale 1ns/1ps
module sim_hall_sense_ctrl;
    localparam int FILT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_raw_i = 3'b000;
    logic       start_n_i = 1'b1;
    logic       brake_i = 1'b0;
    logic       dir_i = 1'b1;
    logic       uv_flt_i = 1'b0;
    logic       ot_flt_i = 1'b0;
    logic [2:0] hall_o;
    logic       strobe_o;
    logic       tach_o;
    logic       fault_o;
    logic       dir_fwd_o;
    logic [1:0] mode_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [2:0] cur_hall = 3'b000;
    logic       exp_tach = 1'b0;

    always #2 clk = ~clk;

    hall_sense_ctrl #(.FILT_CYCLES(FILT)) u0 (
        .clk(clk), .rst_n(rst_n), .hall_raw_i(hall_raw_i), .start_n_i(start_n_i),
        .brake_i(brake_i), .dir_i(dir_i), .uv_flt_i(uv_flt_i), .ot_flt_i(ot_flt_i),
        .hall_o(hall_o), .strobe_o(strobe_o), .tach_o(tach_o), .fault_o(fault_o),
        .dir_fwd_o(dir_fwd_o), .mode_o(mode_o)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic legal(input logic [2:0] c);
        return (c != 3'b000) && (c != 3'b111);
    endfunction

    // drive at negedge; code appears on hall_o at edge FILT+3
    task automatic hall_step(input logic [2:0] v);
        logic exp_strobe;
        exp_strobe = legal(v) && legal(cur_hall) && (v != cur_hall);
        @(negedge clk);
        hall_raw_i = v;
        repeat (FILT + 2) @(posedge clk);
        #1;
        check("R1 hall held before qualify", {1'b0, hall_o}, {1'b0, cur_hall});
        @(posedge clk);
        #1;
        if (exp_strobe) exp_tach = ~exp_tach;
        check("R1 hall accepted", {1'b0, hall_o}, {1'b0, v});
        check("R4 strobe", {3'b0, strobe_o}, {3'b0, exp_strobe});
        check("R5 tach", {3'b0, tach_o}, {3'b0, exp_tach});
        check("R3 fault from code", {3'b0, fault_o}, {3'b0, !legal(v)});
        @(posedge clk);
        #1;
        check("R4 strobe one cycle", {3'b0, strobe_o}, 4'h0);
        check("R5 tach hold", {3'b0, tach_o}, {3'b0, exp_tach});
        cur_hall = v;
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] fwd [6];
        fwd[0] = 3'b001; fwd[1] = 3'b011; fwd[2] = 3'b010;
        fwd[3] = 3'b110; fwd[4] = 3'b100; fwd[5] = 3'b101;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        check("R2 hall", {1'b0, hall_o}, 4'h0);
        check("R2 tach", {3'b0, tach_o}, 4'h0);
        check("R2 strobe", {3'b0, strobe_o}, 4'h0);
        check("R2 mode", {2'b0, mode_o}, 4'h0);
        check("R3 fault at code 000", {3'b0, fault_o}, 4'h1);

        // start requested but hall illegal: R7 off
        @(negedge clk);
        start_n_i = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check("R7 off with illegal hall", {2'b0, mode_o}, 4'h0);

        // enter legal code: no strobe, fault clears, run follows
        hall_step(3'b001);
        @(posedge clk);
        #1;
        check("R9 run after fault clears", {2'b0, mode_o}, 4'h1);

        // R4 R5 forward rotation, two revolutions
        for (int r = 0; r < 2; r++) begin
            for (int k = 1; k <= 6; k++) hall_step(fwd[k % 6]);
        end
        // reverse rotation
        for (int k = 5; k >= 0; k--) hall_step(fwd[k]);

        // R3 every illegal code entered and left, not latched
        hall_step(3'b111);
        @(posedge clk);
        #1;
        check("R7 off on code 111", {2'b0, mode_o}, 4'h0);
        hall_step(3'b101);
        @(posedge clk);
        #1;
        check("R3 fault released, run", {2'b0, mode_o}, 4'h1);
        hall_step(3'b000);
        hall_step(3'b100);
        check("R3 fault low after 000", {3'b0, fault_o}, 4'h0);

        // R1 glitch one clock short of the qualify count
        begin
            int seen;
            seen = 0;
            @(negedge clk);
            hall_raw_i = cur_hall ^ 3'b010;
            repeat (FILT - 1) @(posedge clk);
            @(negedge clk);
            hall_raw_i = cur_hall;
            for (int c = 0; c < FILT + 6; c++) begin
                @(posedge clk);
                #1;
                if (strobe_o || hall_o != cur_hall) seen++;
            end
            check("R1 short glitch ignored", seen[3:0], 4'h0);
            check("R1 tach untouched by glitch", {3'b0, tach_o}, {3'b0, exp_tach});
        end

        // R7 R8 R9 R11 all control combinations with legal hall
        for (int i = 0; i < 16; i++) begin
            logic [3:0] idx;
            logic f;
            logic [1:0] em;
            idx = 4'(i);
            @(negedge clk);
            start_n_i = idx[0];
            brake_i   = idx[1];
            uv_flt_i  = idx[2];
            ot_flt_i  = idx[3];
            f  = idx[2] | idx[3];
            em = (idx[0] || f) ? 2'b00 : (idx[1] ? 2'b10 : 2'b01);
            repeat (2) @(posedge clk);
            #1;
            check("R11 fault from flags", {3'b0, fault_o}, {3'b0, f});
            @(posedge clk);
            #1;
            if (em == 2'b00)      check("R7 mode off",   {2'b0, mode_o}, {2'b0, em});
            else if (em == 2'b10) check("R8 mode brake", {2'b0, mode_o}, {2'b0, em});
            else                  check("R9 mode run",   {2'b0, mode_o}, {2'b0, em});
        end
        @(negedge clk);
        uv_flt_i = 1'b0;
        ot_flt_i = 1'b0;
        start_n_i = 1'b0;
        brake_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R11 not latched", {3'b0, fault_o}, 4'h0);
        check("R6 run code", {2'b0, mode_o}, 4'h1);

        // R10 direction
        @(negedge clk);
        dir_i = 1'b0;
        @(posedge clk);
        #1;
        check("R10 dir delayed", {3'b0, dir_fwd_o}, 4'h1);
        @(posedge clk);
        #1;
        check("R10 reverse", {3'b0, dir_fwd_o}, 4'h0);
        @(negedge clk);
        dir_i = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R10 forward", {3'b0, dir_fwd_o}, 4'h1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule